// File: doc/BRIEF.md
# Credit-ID Central Fabric Arbiter

This block decides which ingress requester may send its next packet across the switch fabric. Each requester presents a request naming a destination index and a 2-bit traffic class. For every {destination, class} pair the arbiter holds a pool of eight buffer tokens. Each token is a 3-bit identifier of one buffer page at the destination. A request is granted only when its pool still holds a free token. The grant message carries the identifier that was taken from the pool. When the destination has drained the page, it sends a credit-return message with that identifier, and the token becomes free again.

In each cycle the arbiter picks at most one winner. Class 0 wins over the other three classes, which share a single lower level. Inside a level, a round-robin pointer gives every requester its turn. Three running counters record the request messages received, the grants issued and the credits received.

Request inputs and the grant output use valid/ready handshakes. A requester keeps `req_valid` and its fields steady until it sees its `req_ready` bit high in the same cycle. The grant output holds `gnt_valid` and all grant fields until `gnt_ready` is high. While the grant output is stalled, no request is accepted. The credit channel has no back-pressure, so every cycle with `crd_valid` high is one credit message.

Top module: `cid_fabric_arbiter`

## Requirements
- R1: After reset every pool holds all eight token IDs, `gnt_valid` and `crd_err` are low, and all three counters read zero.
- R2: A request is accepted in the cycle its `req_ready` bit is high. At most one bit of `req_ready` is high, and only for a requester whose valid is high. The grant (`gnt_req`, `gnt_dest`, `gnt_cls`, `gnt_id`) appears on the next cycle. It stays stable while `gnt_ready` is low, and no request is accepted in such a cycle.
- R3: A pool that has eight grants outstanding accepts no further request until a credit for that pool returns.
- R4: A grant takes the lowest-numbered free token ID (0 to 7) of its pool and removes that ID from the pool.
- R5: A credit return makes its token ID free in its pool. The ID can be allocated from the following cycle.
- R6: A credit for an ID that is already free raises `crd_err` for one cycle, one cycle later, and leaves the pool unchanged.
- R7: A requester of class 0 whose pool has a free token always wins over requesters of classes 1, 2 and 3.
- R8: Inside one level, the search starts at the requester just after the last winner of that level (starting at requester 0 after reset), wrapping round.
- R9: The pool index is the destination concatenated above the 2-bit class, so pools of different destinations or classes are independent.
- R10: `cnt_req` counts request messages, meaning cycles where a requester's valid is high and that requester is not still waiting on an earlier message. `cnt_gnt` counts accepted requests. `cnt_crd` counts every credit message, erroneous ones included. Each count updates one cycle after its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_REQ | Request valid, one bit per requester |
| req_ready | output | NUM_REQ | Request accepted this cycle, one-hot or zero |
| req_dest | input | NUM_REQ*DEST_W | Destination index per requester |
| req_cls | input | NUM_REQ*2 | Class per requester |
| gnt_valid | output | 1 | Grant message valid |
| gnt_ready | input | 1 | Grant consumer ready |
| gnt_req | output | log2(NUM_REQ) | Index of the granted requester |
| gnt_dest | output | DEST_W | Destination of the grant |
| gnt_cls | output | 2 | Class of the grant |
| gnt_id | output | 3 | Allocated token ID |
| crd_valid | input | 1 | Credit-return message valid |
| crd_dest | input | DEST_W | Credit destination |
| crd_cls | input | 2 | Credit class |
| crd_id | input | 3 | Returned token ID |
| crd_err | output | 1 | Credit named an ID that was already free |
| cnt_req | output | CNT_W | Request message count |
| cnt_gnt | output | CNT_W | Grant count |
| cnt_crd | output | CNT_W | Credit message count |

## Verification
`req_ready` is a combinational result of the current inputs and state. The bench therefore drives inputs at the falling edge and samples `req_ready` one time step later, within the same cycle. The grant fields, `crd_err`, the pool contents and the counters all change at the next rising edge. The bench samples them at the falling edge after that edge, where a bench model updated once per rising edge holds its expectations. A credit returned in a cycle is only visible to allocation one cycle later, and the directed cases check that one-cycle gap explicitly.

// File: rtl/cid_arb_pkg.sv
package cid_arb_pkg;
  localparam int CLS_W   = 2;
  localparam int NUM_CLS = 1 << CLS_W;
  localparam int TOK_W   = 3;
  localparam int NUM_TOK = 1 << TOK_W;

  typedef logic [NUM_TOK-1:0] tok_map_t;
  typedef logic [TOK_W-1:0]   tok_id_t;

  // Lowest set bit of a token map; zero when the map is empty.
  function automatic tok_id_t lowest_free(tok_map_t m);
    tok_id_t r;
    r = '0;
    for (int i = NUM_TOK - 1; i >= 0; i--) begin
      if (m[i]) r = TOK_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/cid_token_pool.sv
module cid_token_pool
  import cid_arb_pkg::*;
#(
  parameter int POOL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_en,
  input  logic [POOL_W-1:0] take_idx,
  input  tok_id_t           take_id,
  input  logic              give_en,
  input  logic [POOL_W-1:0] give_idx,
  input  tok_id_t           give_id,
  output tok_map_t          map_all [(1<<POOL_W)],
  output logic              give_dup
);
  localparam int NUM_POOL = 1 << POOL_W;

  tok_map_t map_q [NUM_POOL];

  // A returned ID that is already free is a duplicate and is dropped.
  assign give_dup = give_en & map_q[give_idx][give_id];

  for (genvar p = 0; p < NUM_POOL; p++) begin : g_pool
    tok_map_t clr_p, set_p;

    always_comb begin
      clr_p = '0;
      set_p = '0;
      if (take_en && take_idx == POOL_W'(p)) clr_p[take_id] = 1'b1;
      if (give_en && !give_dup && give_idx == POOL_W'(p)) set_p[give_id] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q[p] <= '1;
      else        map_q[p] <= (map_q[p] & ~clr_p) | set_p;
    end

    assign map_all[p] = map_q[p];
  end
endmodule

// File: rtl/cid_rr_pick.sv
module cid_rr_pick #(
  parameter  int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cand,
  input  logic          adv,
  output logic          any,
  output logic [IW-1:0] win
);
  logic [IW-1:0] ptr_q;

  assign any = |cand;

  // Search from the pointer upward, wrapping round.
  always_comb begin
    logic found;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (!found && cand[j]) begin
        found = 1'b1;
        win   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/cid_stat_cnt.sv
module cid_stat_cnt #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_req,
  input  logic             inc_gnt,
  input  logic             inc_crd,
  output logic [CNT_W-1:0] cnt_req,
  output logic [CNT_W-1:0] cnt_gnt,
  output logic [CNT_W-1:0] cnt_crd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_req <= '0;
      cnt_gnt <= '0;
      cnt_crd <= '0;
    end else begin
      cnt_req <= cnt_req + CNT_W'(inc_req);
      cnt_gnt <= cnt_gnt + CNT_W'(inc_gnt);
      cnt_crd <= cnt_crd + CNT_W'(inc_crd);
    end
  end
endmodule

// File: rtl/cid_fabric_arbiter.sv
module cid_fabric_arbiter
  import cid_arb_pkg::*;
#(
  parameter  int NUM_REQ = 4,
  parameter  int DEST_W  = 3,
  parameter  int CNT_W   = 32,
  localparam int REQ_W   = $clog2(NUM_REQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req_valid,
  output logic [NUM_REQ-1:0]        req_ready,
  input  logic [NUM_REQ*DEST_W-1:0] req_dest,
  input  logic [NUM_REQ*CLS_W-1:0]  req_cls,
  output logic                      gnt_valid,
  input  logic                      gnt_ready,
  output logic [REQ_W-1:0]          gnt_req,
  output logic [DEST_W-1:0]         gnt_dest,
  output logic [CLS_W-1:0]          gnt_cls,
  output logic [TOK_W-1:0]          gnt_id,
  input  logic                      crd_valid,
  input  logic [DEST_W-1:0]         crd_dest,
  input  logic [CLS_W-1:0]          crd_cls,
  input  logic [TOK_W-1:0]          crd_id,
  output logic                      crd_err,
  output logic [CNT_W-1:0]          cnt_req,
  output logic [CNT_W-1:0]          cnt_gnt,
  output logic [CNT_W-1:0]          cnt_crd
);
  localparam int POOL_W   = DEST_W + CLS_W;
  localparam int NUM_POOL = 1 << POOL_W;
  localparam int INC_W    = $clog2(NUM_REQ + 1);

  tok_map_t           pool_map [NUM_POOL];
  logic [POOL_W-1:0]  pidx [NUM_REQ];
  logic [NUM_REQ-1:0] elig, cand_hi, cand_lo, pend_q, new_req;
  logic               hi_any, lo_any, accept, out_free, give_dup;
  logic [REQ_W-1:0]   hi_win, lo_win, win_idx;
  logic [POOL_W-1:0]  win_pool;
  tok_id_t            win_tok;

  // Pool lookup and level split per requester.
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    logic [CLS_W-1:0] cls_i;
    assign cls_i      = req_cls[i*CLS_W +: CLS_W];
    assign pidx[i]    = {req_dest[i*DEST_W +: DEST_W], cls_i};
    assign elig[i]    = req_valid[i] & (|pool_map[pidx[i]]);
    assign cand_hi[i] = elig[i] & (cls_i == '0);
    assign cand_lo[i] = elig[i] & (cls_i != '0);
  end

  assign out_free = ~gnt_valid | gnt_ready;
  assign accept   = out_free & (hi_any | lo_any);
  assign win_idx  = hi_any ? hi_win : lo_win;
  assign win_pool = pidx[win_idx];
  assign win_tok  = lowest_free(pool_map[win_pool]);
  assign req_ready = accept ? (NUM_REQ'(1) << win_idx) : '0;

  cid_rr_pick #(.N(NUM_REQ)) u_pick_hi (
    .clk(clk), .rst_n(rst_n), .cand(cand_hi),
    .adv(accept & hi_any), .any(hi_any), .win(hi_win)
  );

  cid_rr_pick #(.N(NUM_REQ)) u_pick_lo (
    .clk(clk), .rst_n(rst_n), .cand(cand_lo),
    .adv(accept & ~hi_any), .any(lo_any), .win(lo_win)
  );

  cid_token_pool #(.POOL_W(POOL_W)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .take_en(accept), .take_idx(win_pool), .take_id(win_tok),
    .give_en(crd_valid), .give_idx({crd_dest, crd_cls}), .give_id(crd_id),
    .map_all(pool_map), .give_dup(give_dup)
  );

  // Grant output register with back-pressure.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_req   <= '0;
      gnt_dest  <= '0;
      gnt_cls   <= '0;
      gnt_id    <= '0;
    end else if (accept) begin
      gnt_valid <= 1'b1;
      gnt_req   <= win_idx;
      gnt_dest  <= win_pool[POOL_W-1:CLS_W];
      gnt_cls   <= win_pool[CLS_W-1:0];
      gnt_id    <= win_tok;
    end else if (gnt_ready) begin
      gnt_valid <= 1'b0;
    end
  end

  // A message counts once: in its first cycle of valid.
  assign new_req = req_valid & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      crd_err <= 1'b0;
    end else begin
      pend_q  <= req_valid & ~req_ready;
      crd_err <= give_dup;
    end
  end

  cid_stat_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .inc_req(INC_W'($countones(new_req))),
    .inc_gnt(accept), .inc_crd(crd_valid),
    .cnt_req(cnt_req), .cnt_gnt(cnt_gnt), .cnt_crd(cnt_crd)
  );
endmodule

// File: rtl/cid_arb_chk.sv
module cid_arb_chk #(
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = 32,
  parameter int REQ_W   = 2,
  parameter int DEST_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req_valid,
  input logic [NUM_REQ-1:0] req_ready,
  input logic [NUM_REQ-1:0] cand_hi,
  input logic               gnt_valid,
  input logic               gnt_ready,
  input logic [REQ_W-1:0]   gnt_req,
  input logic [DEST_W-1:0]  gnt_dest,
  input logic [1:0]         gnt_cls,
  input logic [2:0]         gnt_id,
  input logic               crd_valid,
  input logic               crd_err,
  input logic [CNT_W-1:0]   cnt_gnt,
  input logic [CNT_W-1:0]   cnt_crd
);
  p_ready_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_ready_has_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  p_grant_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> gnt_valid);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_id) && $stable(gnt_req)
                                   && $stable(gnt_dest) && $stable(gnt_cls)));

  p_stall_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_ready) |-> (req_ready == '0));

  p_class0_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_ready) && (|cand_hi)) |-> ((req_ready & ~cand_hi) == '0));

  p_dup_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crd_err |-> $past(crd_valid));

  p_gnt_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (cnt_gnt == $past(cnt_gnt) + 1'b1));

  p_gnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_ready) |=> $stable(cnt_gnt));

  p_crd_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    crd_valid |=> (cnt_crd == $past(cnt_crd) + 1'b1));
endmodule

bind cid_fabric_arbiter cid_arb_chk #(
  .NUM_REQ(NUM_REQ), .CNT_W(CNT_W), .REQ_W(REQ_W), .DEST_W(DEST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cand_hi(cand_hi), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
  .gnt_req(gnt_req), .gnt_dest(gnt_dest), .gnt_cls(gnt_cls), .gnt_id(gnt_id),
  .crd_valid(crd_valid), .crd_err(crd_err), .cnt_gnt(cnt_gnt), .cnt_crd(cnt_crd)
);

// File: tb/tb_cid_fabric_arbiter.sv
module tb_cid_fabric_arbiter;
  localparam int N  = 4;
  localparam int DW = 3;
  localparam int CW = 32;
  localparam int NP = 1 << (DW + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    req_valid, req_ready;
  logic [N*DW-1:0] req_dest;
  logic [N*2-1:0]  req_cls;
  logic            gnt_valid, gnt_ready, crd_valid, crd_err;
  logic [1:0]      gnt_req, gnt_cls, crd_cls;
  logic [DW-1:0]   gnt_dest, crd_dest;
  logic [2:0]      gnt_id, crd_id;
  logic [CW-1:0]   cnt_req, cnt_gnt, cnt_crd;

  // Bench-side requester state
  logic [N-1:0] b_valid;
  int           b_dest [N];
  int           b_cls  [N];

  always_comb begin
    req_valid = b_valid;
    for (int i = 0; i < N; i++) begin
      req_dest[i*DW +: DW] = DW'(b_dest[i]);
      req_cls[i*2 +: 2]    = 2'(b_cls[i]);
    end
  end

  cid_fabric_arbiter #(.NUM_REQ(N), .DEST_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_cls(req_cls), .gnt_valid(gnt_valid),
    .gnt_ready(gnt_ready), .gnt_req(gnt_req), .gnt_dest(gnt_dest),
    .gnt_cls(gnt_cls), .gnt_id(gnt_id), .crd_valid(crd_valid),
    .crd_dest(crd_dest), .crd_cls(crd_cls), .crd_id(crd_id), .crd_err(crd_err),
    .cnt_req(cnt_req), .cnt_gnt(cnt_gnt), .cnt_crd(cnt_crd)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [N-1:0] obs_ready;

  // Model state
  logic [7:0] m_map [NP];
  int m_ptr_hi, m_ptr_lo;
  logic [N-1:0] m_pend;
  logic m_gv, m_err;
  int m_greq, m_gdest, m_gcls, m_gid;
  int m_creq, m_cgnt, m_ccrd;
  int o_pool [64];
  int o_id   [64];
  int o_cnt;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int pidx(input int d, input int c);
    return d * 4 + c;
  endfunction

  function automatic int lowest(input logic [7:0] m);
    for (int k = 0; k < 8; k++) if (m[k]) return k;
    return 0;
  endfunction

  function automatic int rr(input logic [N-1:0] c, input int ptr);
    for (int k = 0; k < N; k++) begin
      int j;
      j = (ptr + k) % N;
      if (c[j]) return j;
    end
    return -1;
  endfunction

  function automatic int model_pick();
    logic [N-1:0] hi, lo;
    hi = '0;
    lo = '0;
    if (m_gv && !gnt_ready) return -1;
    for (int i = 0; i < N; i++) begin
      if (b_valid[i] && m_map[pidx(b_dest[i], b_cls[i])] != 8'h00) begin
        if (b_cls[i] == 0) hi[i] = 1'b1;
        else               lo[i] = 1'b1;
      end
    end
    if (hi != '0) return rr(hi, m_ptr_hi);
    if (lo != '0) return rr(lo, m_ptr_lo);
    return -1;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NP; p++) m_map[p] = 8'hFF;
    m_ptr_hi = 0; m_ptr_lo = 0; m_pend = '0; m_gv = 1'b0; m_err = 1'b0;
    m_greq = 0; m_gdest = 0; m_gcls = 0; m_gid = 0;
    m_creq = 0; m_cgnt = 0; m_ccrd = 0; o_cnt = 0;
  endtask

  task automatic model_update(input int w);
    logic err;
    int cp;
    err = 1'b0;
    cp = pidx(int'(crd_dest), int'(crd_cls));
    for (int i = 0; i < N; i++) if (b_valid[i] && !m_pend[i]) m_creq++;
    for (int i = 0; i < N; i++) m_pend[i] = b_valid[i] && (w != i);
    if (crd_valid) begin
      m_ccrd++;
      err = m_map[cp][crd_id];
    end
    if (w >= 0) begin
      int p, id;
      p  = pidx(b_dest[w], b_cls[w]);
      id = lowest(m_map[p]);
      m_map[p][id] = 1'b0;
      m_gv = 1'b1; m_greq = w; m_gdest = b_dest[w]; m_gcls = b_cls[w]; m_gid = id;
      m_cgnt++;
      if (b_cls[w] == 0) m_ptr_hi = (w + 1) % N;
      else               m_ptr_lo = (w + 1) % N;
      if (o_cnt < 64) begin
        o_pool[o_cnt] = p; o_id[o_cnt] = id; o_cnt++;
      end
    end else if (gnt_ready) begin
      m_gv = 1'b0;
    end
    if (crd_valid && !err) m_map[cp][crd_id] = 1'b1;
    m_err = crd_valid && err;
  endtask

  // One cycle: inputs already set at the falling edge.
  task automatic tick();
    int w;
    logic [N-1:0] exp_r;
    #1;
    w = model_pick();
    exp_r = (w >= 0) ? (N'(1) << w) : '0;
    obs_ready = req_ready;
    check("R2/R7/R8 req_ready selection", 64'(req_ready), 64'(exp_r));
    @(posedge clk);
    model_update(w);
    @(negedge clk);
    check("R2 gnt_valid", 64'(gnt_valid), 64'(m_gv));
    if (m_gv) begin
      check("R2 gnt_req", 64'(gnt_req), 64'(m_greq));
      check("R9 gnt_dest", 64'(gnt_dest), 64'(m_gdest));
      check("R9 gnt_cls", 64'(gnt_cls), 64'(m_gcls));
      check("R4 gnt_id", 64'(gnt_id), 64'(m_gid));
    end
    check("R6 crd_err", 64'(crd_err), 64'(m_err));
    check("R10 cnt_req", 64'(cnt_req), 64'(m_creq));
    check("R10 cnt_gnt", 64'(cnt_gnt), 64'(m_cgnt));
    check("R10 cnt_crd", 64'(cnt_crd), 64'(m_ccrd));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    b_valid = '0;
    for (int i = 0; i < N; i++) begin b_dest[i] = 0; b_cls[i] = 0; end
    gnt_ready = 1'b1; crd_valid = 1'b0; crd_dest = '0; crd_cls = '0; crd_id = '0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_req(input int i, input int d, input int c);
    b_valid[i] = 1'b1; b_dest[i] = d; b_cls[i] = c;
  endtask

  task automatic send_crd(input int d, input int c, input int id);
    crd_valid = 1'b1; crd_dest = DW'(d); crd_cls = 2'(c); crd_id = 3'(id);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1: reset state
    check("R1 gnt_valid after reset", 64'(gnt_valid), 64'd0);
    check("R1 crd_err after reset", 64'(crd_err), 64'd0);
    check("R1 cnt_req after reset", 64'(cnt_req), 64'd0);
    check("R1 cnt_gnt after reset", 64'(cnt_gnt), 64'd0);
    check("R1 cnt_crd after reset", 64'(cnt_crd), 64'd0);

    // R4/R3: drain one pool, IDs in ascending order, then blocked
    set_req(0, 3, 1);
    for (int k = 0; k < 10; k++) begin
      tick();
      if (k < 8) check("R4 ascending token id", 64'(gnt_id), 64'(k));
      if (k == 8) begin
        check("R3 no grant on empty pool", 64'(obs_ready), 64'd0);
        check("R3 gnt_valid low on empty pool", 64'(gnt_valid), 64'd0);
      end
    end
    check("R10 request messages", 64'(cnt_req), 64'd9);
    check("R10 grants", 64'(cnt_gnt), 64'd8);

    // R5: credit visible only from next cycle
    send_crd(3, 1, 5);
    tick();
    check("R5 credit not usable same cycle", 64'(obs_ready), 64'd0);
    crd_valid = 1'b0;
    tick();
    check("R5 grant after credit", 64'(obs_ready), 64'd1);
    check("R5 returned id reused", 64'(gnt_id), 64'd5);

    // R6: duplicate credit
    b_valid[0] = 1'b0;
    send_crd(3, 1, 5);
    tick();
    check("R6 first credit clean", 64'(crd_err), 64'd0);
    tick();
    check("R6 duplicate flagged", 64'(crd_err), 64'd1);
    crd_valid = 1'b0;
    set_req(0, 3, 1);
    tick();
    check("R6 err is a pulse", 64'(crd_err), 64'd0);
    check("R6 single token granted", 64'(gnt_id), 64'd5);
    tick();
    check("R6 duplicate added no token", 64'(obs_ready), 64'd0);

    // R7: class 0 wins
    do_reset();
    set_req(0, 0, 2); set_req(1, 1, 0); set_req(2, 0, 3);
    tick();
    check("R7 class 0 first", 64'(obs_ready), 64'h2);
    b_valid[1] = 1'b0;
    tick();
    check("R8 low level starts at 0", 64'(obs_ready), 64'h1);

    // R8: round-robin order
    do_reset();
    for (int i = 0; i < N; i++) set_req(i, 2, 1);
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R8 rotation", 64'(obs_ready), 64'(N'(1) << (k % N)));
    end

    // R9: pools independent
    do_reset();
    set_req(0, 4, 2);
    for (int k = 0; k < 9; k++) tick();
    check("R9 pool 4/2 exhausted", 64'(obs_ready), 64'd0);
    b_cls[0] = 3;
    tick();
    check("R9 neighbour pool grants", 64'(obs_ready), 64'd1);
    check("R9 neighbour pool id", 64'(gnt_id), 64'd0);

    // R2: stall holds output and blocks acceptance
    do_reset();
    gnt_ready = 1'b0;
    set_req(0, 0, 1); set_req(1, 0, 1);
    tick();
    check("R2 first accept", 64'(obs_ready), 64'h1);
    tick();
    check("R2 stalled no accept", 64'(obs_ready), 64'd0);
    check("R2 held id", 64'(gnt_id), 64'd0);
    check("R2 held req", 64'(gnt_req), 64'd0);
    gnt_ready = 1'b1;
    tick();
    check("R2 handoff accept", 64'(obs_ready), 64'h2);
    check("R2 new grant id", 64'(gnt_id), 64'd1);

    // Random traffic against the model
    do_reset();
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < N; i++) begin
        if (!b_valid[i] || obs_ready[i]) begin
          if ($urandom % 10 < 5) set_req(i, int'($urandom % 2), int'($urandom % 4));
          else b_valid[i] = 1'b0;
        end
      end
      gnt_ready = ($urandom % 4) != 0;
      crd_valid = 1'b0;
      if (o_cnt > 0 && ($urandom % 3) == 0) begin
        int k;
        k = int'($urandom % o_cnt);
        send_crd(o_pool[k] / 4, o_pool[k] % 4, o_id[k]);
        o_cnt--;
        o_pool[k] = o_pool[o_cnt];
        o_id[k]   = o_id[o_cnt];
      end else if (($urandom % 30) == 0) begin
        int p;
        p = int'($urandom % 8);
        if (m_map[p] != 8'h00) send_crd(p / 4, p % 4, lowest(m_map[p]));
      end
      obs_ready = '0;
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule